// File: doc/BRIEF.md
# Dual-Clock Serial Line Delay Memory

This block stores one video line of 5048 eight-bit samples and plays it back through an independent read port. The writer and the reader each run on their own clock and each walk a private address counter through the array one step per enabled edge. The distance between the two counters is the delay. A writer and reader that both run every cycle give back each sample exactly one line later. Holding one side's enable high for a number of cycles stretches or shortens the offset anywhere from 40 up to 5048 samples.

Each port has an active-low pointer clear that restarts its counter at address zero. On the write side, an accepted sample first sits in a one-word holding register. It is copied into the array when the next sample is accepted or when the write pointer is cleared. A system therefore finishes a line with a write clear, so that the final sample is stored. After power-up the counters hold no meaningful value. The read output carries no defined data until the first read clear, and the write side stores nothing known until the first write clear.

Top module: `line_delay_mem`

## Requirements
- R1: The array holds DEPTH (default 5048) words of WIDTH (default 8) bits. With both enables held low after clearing both pointers in the same cycle, every word read equals the word written DEPTH write edges earlier.
- R2: A write is accepted only on a rising wrClk edge with wrEnN low, and the write pointer then advances by one. An edge with wrEnN high stores nothing and leaves the pointer where it was.
- R3: A read happens only on a rising rdClk edge with rdEnN low. rdData takes the addressed word at that same edge (one registered stage). With rdEnN high, rdData keeps its value.
- R4: The gap between the number of write and read edges with the enable low sets the delay. A delay of D words, for any D from 40 to DEPTH, returns the sample written D positions earlier.
- R5: wrRstN low on a rising wrClk edge clears the write pointer. If wrEnN is also low on that edge, the word is written to address 0 and the pointer moves to 1. Otherwise the next accepted write goes to address 0.
- R6: rdRstN low on a rising rdClk edge clears the read pointer. If rdEnN is also low on that edge, address 0 is read and the pointer moves to 1. Otherwise the next read uses address 0.
- R7: The most recently accepted word stays in a holding register and is not visible to reads. It enters the array on the next accepted write or on a write clear. Until then, a read of its address returns the word stored there before.
- R8: Both pointers step from DEPTH-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrEnN | input | 1 | Active-low write enable |
| wrRstN | input | 1 | Active-low write pointer clear |
| wrData | input | WIDTH | Sample to write |
| rdClk | input | 1 | Read-side clock |
| rdEnN | input | 1 | Active-low read enable |
| rdRstN | input | 1 | Active-low read pointer clear |
| rdData | output | WIDTH | Registered read sample (unknown until the first read clear) |

## Verification
A write decides the pointer at the same edge, but the word only becomes readable one accepted write or write clear later. The bench keeps that one-step lag in its reference array. A read updates rdData at the rdClk edge that performs it. In each cycle the bench raises wrClk first and rdClk a nanosecond later, then samples rdData after both clocks have fallen, so each check sees the result of exactly the edge just issued. Hold checks compare rdData before and after an edge with rdEnN high. Delay checks compare the j-th read after the read clear with the pattern word of index j.

// File: rtl/lmem_pkg.sv
`timescale 1ns/1ps
package lmem_pkg;

  // write-side strobes from control to datapath
  typedef struct packed {
    logic commit;  // flush the held word into the array
    logic stage;   // capture wrData into the holding register
  } wrStrobe_t;

  // read-side strobes from control to datapath
  typedef struct packed {
    logic fetch;   // load the output register from the array
    logic show;    // read pointer has been cleared at least once
  } rdStrobe_t;

endpackage

// File: rtl/lmem_ptr.sv
`timescale 1ns/1ps
module lmem_ptr #(
  parameter int DEPTH = 5048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          enN,
  input  logic          rstN,
  output logic [AW-1:0] useAddr,
  output logic [AW-1:0] ptrQ,
  output logic          armed
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr    = '0;
  logic          armedQ = 1'b0;

  function automatic logic [AW-1:0] stepOf(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  // a clear in this cycle redirects the access to address zero
  always_comb useAddr = rstN ? ptr : '0;

  always_ff @(posedge clk) begin
    if (!rstN) armedQ <= 1'b1;
    if (!enN)       ptr <= stepOf(useAddr);
    else if (!rstN) ptr <= '0;
  end

  assign ptrQ  = ptr;
  assign armed = armedQ;

endmodule

// File: rtl/lmem_ctrl.sv
`timescale 1ns/1ps
module lmem_ctrl
  import lmem_pkg::*;
#(
  parameter int DEPTH = 5048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          wrEnN,
  input  logic          wrRstN,
  input  logic          rdClk,
  input  logic          rdEnN,
  input  logic          rdRstN,
  output wrStrobe_t     wrStb,
  output rdStrobe_t     rdStb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] wrPtrQ,
  output logic [AW-1:0] rdPtrQ,
  output logic          wrArmed,
  output logic          rdArmed
);

  // index 0 is the write port, index 1 the read port
  logic [1:0]    clkV, enNV, rstNV, armedV;
  logic [AW-1:0] useV [2];
  logic [AW-1:0] ptrV [2];

  assign clkV  = {rdClk,  wrClk};
  assign enNV  = {rdEnN,  wrEnN};
  assign rstNV = {rdRstN, wrRstN};

  for (genvar p = 0; p < 2; p++) begin : g_port
    lmem_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk    (clkV[p]),
      .enN    (enNV[p]),
      .rstN   (rstNV[p]),
      .useAddr(useV[p]),
      .ptrQ   (ptrV[p]),
      .armed  (armedV[p])
    );
  end

  always_comb begin
    wrStb.stage  = !wrEnN;
    wrStb.commit = !wrEnN || !wrRstN;
    rdStb.fetch  = !rdEnN;
    rdStb.show   = armedV[1];
  end

  assign wrAddr  = useV[0];
  assign rdAddr  = useV[1];
  assign wrPtrQ  = ptrV[0];
  assign rdPtrQ  = ptrV[1];
  assign wrArmed = armedV[0];
  assign rdArmed = armedV[1];

endmodule

// File: rtl/lmem_datapath.sv
`timescale 1ns/1ps
module lmem_datapath
  import lmem_pkg::*;
#(
  parameter int DEPTH = 5048,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  wrStrobe_t        wrStb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdClk,
  input  rdStrobe_t        rdStb,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  logic             holdValid = 1'b0;
  logic [AW-1:0]    holdAddr  = '0;
  logic [WIDTH-1:0] holdData  = '0;
  logic [WIDTH-1:0] outQ      = '0;

  // holding register: the previous word is flushed when a new one arrives
  always_ff @(posedge wrClk) begin
    if (wrStb.commit && holdValid) mem[holdAddr] <= holdData;
    if (wrStb.stage) begin
      holdValid <= 1'b1;
      holdAddr  <= wrAddr;
      holdData  <= wrData;
    end else if (wrStb.commit) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge rdClk) begin
    if (rdStb.fetch) outQ <= mem[rdAddr];
  end

  assign rdData = rdStb.show ? outQ : 'x;

endmodule

// File: rtl/line_delay_mem.sv
`timescale 1ns/1ps
module line_delay_mem
  import lmem_pkg::*;
#(
  parameter int DEPTH = 5048,
  parameter int WIDTH = 8
) (
  input  logic             wrClk,
  input  logic             wrEnN,
  input  logic             wrRstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdClk,
  input  logic             rdEnN,
  input  logic             rdRstN,
  output logic [WIDTH-1:0] rdData
);

  localparam int AW = $clog2(DEPTH);

  wrStrobe_t     wrStb;
  rdStrobe_t     rdStb;
  logic [AW-1:0] wrAddr, rdAddr, wrPtrQ, rdPtrQ;
  logic          wrArmed, rdArmed;

  lmem_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .wrClk  (wrClk),
    .wrEnN  (wrEnN),
    .wrRstN (wrRstN),
    .rdClk  (rdClk),
    .rdEnN  (rdEnN),
    .rdRstN (rdRstN),
    .wrStb  (wrStb),
    .rdStb  (rdStb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrPtrQ (wrPtrQ),
    .rdPtrQ (rdPtrQ),
    .wrArmed(wrArmed),
    .rdArmed(rdArmed)
  );

  lmem_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_dp (
    .wrClk (wrClk),
    .wrStb (wrStb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdClk (rdClk),
    .rdStb (rdStb),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

endmodule

// File: rtl/line_delay_mem_chk.sv
`timescale 1ns/1ps
module line_delay_mem_chk #(
  parameter int DEPTH = 5048,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic             wrClk,
  input logic             wrEnN,
  input logic             wrRstN,
  input logic             rdClk,
  input logic             rdEnN,
  input logic             rdRstN,
  input logic [WIDTH-1:0] rdData,
  input logic [AW-1:0]    wrPtrQ,
  input logic [AW-1:0]    rdPtrQ,
  input logic             wrArmed,
  input logic             rdArmed
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] nextOf(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  // R2: accepted write moves the pointer one place (R8 wrap included)
  a_r2_ptr_step: assert property (@(posedge wrClk) disable iff (!wrArmed)
    (!wrEnN && wrRstN) |=> wrPtrQ == nextOf($past(wrPtrQ)));

  // R2: idle write edge leaves the pointer alone
  a_r2_ptr_hold: assert property (@(posedge wrClk) disable iff (!wrArmed)
    (wrEnN && wrRstN) |=> $stable(wrPtrQ));

  // R5: write clear lands on 0, or on 1 when a write rides along
  a_r5_wr_clear: assert property (@(posedge wrClk) disable iff (!wrArmed)
    (!wrRstN) |=> wrPtrQ == ($past(wrEnN) ? '0 : AW'(1)));

  // R6: read clear lands on 0, or on 1 when a read rides along
  a_r6_rd_clear: assert property (@(posedge rdClk) disable iff (!rdArmed)
    (!rdRstN) |=> rdPtrQ == ($past(rdEnN) ? '0 : AW'(1)));

  // R3: output holds on an idle read edge
  a_r3_out_hold: assert property (@(posedge rdClk) disable iff (!rdArmed)
    (rdEnN && rdRstN) |=> $stable(rdData));

  // R8: pointers never leave the array
  a_r8_wr_range: assert property (@(posedge wrClk) disable iff (!wrArmed)
    wrPtrQ <= LAST);
  a_r8_rd_range: assert property (@(posedge rdClk) disable iff (!rdArmed)
    rdPtrQ <= LAST);

endmodule

bind line_delay_mem line_delay_mem_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_chk (
  .wrClk  (wrClk),
  .wrEnN  (wrEnN),
  .wrRstN (wrRstN),
  .rdClk  (rdClk),
  .rdEnN  (rdEnN),
  .rdRstN (rdRstN),
  .rdData (rdData),
  .wrPtrQ (wrPtrQ),
  .rdPtrQ (rdPtrQ),
  .wrArmed(wrArmed),
  .rdArmed(rdArmed)
);

// File: tb/line_delay_mem_tb.sv
`timescale 1ns/1ps
module line_delay_mem_tb;

  localparam int DEPTH = 5048;
  localparam int WIDTH = 8;
  localparam int VEC_N = 5;
  // {delay in words, reads checked}
  localparam int VEC [VEC_N][2] = '{'{40, 64}, '{41, 64}, '{777, 48}, '{2048, 48}, '{5048, 64}};

  logic             wrClk = 0, rdClk = 0;
  logic             wrEnN = 1, wrRstN = 1, rdEnN = 1, rdRstN = 1;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;

  int nTests = 0, nFail = 0;

  // reference model built from the requirements
  int refMem [DEPTH];
  bit pendV = 0, wKnown = 0, rKnown = 0;
  int pendA = 0, pendD = 0, wp = 0, rp = 0;

  line_delay_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .wrClk(wrClk), .wrEnN(wrEnN), .wrRstN(wrRstN), .wrData(wrData),
    .rdClk(rdClk), .rdEnN(rdEnN), .rdRstN(rdRstN), .rdData(rdData)
  );

  function automatic int nxt(input int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  function automatic logic [WIDTH-1:0] pat(input int v, input int k);
    return WIDTH'((k * 37 + v * 101 + 5) ^ (k >> 5));
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one 10 ns cycle; wrClk rises 1 ns before rdClk; sample after both fall
  task automatic step(input bit weN, input bit wrN, input logic [WIDTH-1:0] d,
                      input bit reN, input bit rrN,
                      input bit doW = 1, input bit doR = 1, input string req = "");
    logic [WIDTH-1:0] prevOut;
    int ua;
    wrEnN = weN; wrRstN = wrN; wrData = d; rdEnN = reN; rdRstN = rrN;
    prevOut = rdData;
    #2 if (doW) wrClk = 1;
    #1 if (doR) rdClk = 1;
    #2 wrClk = 0; rdClk = 0;
    #5;
    if (doW) begin
      ua = wrN ? wp : 0;
      if (!wrN) wKnown = 1;
      if ((!weN || !wrN) && pendV) refMem[pendA] = pendD;
      if (!weN && wKnown) begin pendV = 1; pendA = ua; pendD = int'(d); end
      else if (!wrN) pendV = 0;
      if (!weN) wp = nxt(ua); else if (!wrN) wp = 0;
    end
    if (doR) begin
      ua = rrN ? rp : 0;
      if (!rrN) rKnown = 1;
      if (!reN) begin
        if (req != "" && rKnown && refMem[ua] >= 0) check(req, rdData, WIDTH'(refMem[ua]));
        rp = nxt(ua);
      end else begin
        if (!rrN) rp = 0;
        if (req != "" && rKnown) check({req, " hold"}, rdData, prevOut);
      end
    end
  endtask

  initial begin
    #1_500_000;
    nFail++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = -1;

    // power-up: dummy cycles on both ports, then both clears together
    for (int i = 0; i < 18; i++) step(0, 1, 8'hFF, 0, 1);
    step(1, 0, 8'h00, 1, 0);

    // ---- vector table: delay set by enable gating (R4, R1 at full line, R8 write wrap)
    for (int v = 0; v < VEC_N; v++) begin
      int dly, nrd;
      dly = VEC[v][0];
      nrd = VEC[v][1];
      step(1, 0, 8'h00, 1, 1);                       // clear write pointer
      for (int k = 0; k < dly; k++) step(0, 1, pat(v, k), 1, 1);
      for (int j = 0; j < nrd; j++) begin
        step(0, 1, pat(v, dly + j), 0, (j == 0) ? 1'b0 : 1'b1);
        check((dly == DEPTH) ? "R1 full-line delay" : "R4 gated delay", rdData, pat(v, j));
      end
    end

    // ---- R8: read pointer wraps after DEPTH reads (array now fully known)
    step(1, 0, 8'h00, 1, 1);                         // flush held word
    step(1, 1, 8'h00, 0, 0, 1, 1, "R6 read clear addr0");
    for (int i = 1; i < DEPTH; i++) step(1, 1, 8'h00, 0, 1, 0, 1, "R8 read sweep");
    step(1, 1, 8'h00, 0, 1, 0, 1, "R8 read wrap to 0");
    check("R8 wrap value", rdData, WIDTH'(refMem[0]));

    // ---- R5 write clear then sequential writes, read back (R2, R6)
    step(1, 0, 8'h00, 1, 1);
    for (int i = 0; i < 8; i++) step(0, 1, 8'hA0 + 8'(i), 1, 1, 1, 0);
    step(1, 0, 8'h00, 1, 1, 1, 0);
    step(1, 1, 8'h00, 0, 0, 0, 1);
    check("R5 first write at addr0", rdData, 8'hA0);
    for (int i = 1; i < 8; i++) step(1, 1, 8'h00, 0, 1, 0, 1, "R2 sequential write");

    // ---- R2 gating: idle write edges store nothing and do not move the pointer
    step(1, 0, 8'h00, 1, 1, 1, 0);
    step(0, 1, 8'h11, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 8'hEE, 1, 1, 1, 0);
    step(0, 1, 8'h22, 1, 1, 1, 0);
    step(1, 0, 8'h00, 1, 1, 1, 0);
    step(1, 1, 8'h00, 0, 0, 0, 1);
    check("R2 gated write addr0", rdData, 8'h11);
    step(1, 1, 8'h00, 0, 1, 0, 1);
    check("R2 gated write addr1", rdData, 8'h22);

    // ---- R3 hold: idle read edges keep the output
    step(1, 1, 8'h00, 1, 1, 0, 1, "R3 idle read");
    check("R3 output held", rdData, 8'h22);
    step(1, 1, 8'h00, 1, 1, 0, 1, "R3 idle read");

    // ---- R7 holding register
    step(1, 0, 8'h00, 1, 1, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 8'h55, 1, 1, 1, 0);
    step(1, 0, 8'h00, 1, 1, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 8'hC0 + 8'(i), 1, 1, 1, 0);
    step(1, 1, 8'h00, 0, 0, 0, 1);
    check("R7 committed addr0", rdData, 8'hC0);
    for (int i = 1; i < 4; i++) begin
      step(1, 1, 8'h00, 0, 1, 0, 1);
      check("R7 committed word", rdData, 8'hC0 + 8'(i));
    end
    step(1, 1, 8'h00, 0, 1, 0, 1);
    check("R7 held word not yet visible", rdData, 8'h55);
    step(1, 0, 8'h00, 1, 1, 1, 0);                   // write clear pushes it in
    step(1, 1, 8'h00, 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 1, 8'h00, 0, 1, 0, 1);
    step(1, 1, 8'h00, 0, 1, 0, 1);
    check("R7 held word after write clear", rdData, 8'hC4);

    // ---- R5/R6 clear and access in the same edge
    step(0, 0, 8'h71, 1, 1, 1, 0);
    step(0, 1, 8'h72, 1, 1, 1, 0);
    step(1, 0, 8'h00, 1, 1, 1, 0);
    step(1, 1, 8'h00, 0, 0, 0, 1);
    check("R5 clear+write uses addr0", rdData, 8'h71);
    step(1, 1, 8'h00, 0, 1, 0, 1);
    check("R6 clear+read moves pointer to 1", rdData, 8'h72);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule